// File: doc/BRIEF.md
# Endpoint-Zero Receive Register Block

This block holds the CPU-visible state of endpoint zero in a USB device controller. On one side it takes a byte stream from the packet engine: bytes of a SETUP or OUT data packet, with first-byte and last-byte markers. It also takes a pulse when the host completes the status-stage OUT, and a pulse when an armed IN packet has gone out. On the other side is a small register bus with four byte-wide locations:

- a control/status register with flag bits and write-one action bits;
- a data port that pops a 16-byte receive FIFO;
- a byte-count register;
- a control register holding the interrupt enable.

A level interrupt tells firmware that a packet is waiting or that the control transfer has ended.

The byte stream uses valid/ready. A byte transfers on a clock edge where `rx_valid` and `rx_ready` are both high. `rx_ready` is held high at all times, so the block applies no back-pressure. Bytes the block cannot keep are discarded, and the loss is recorded in a sticky overrun flag.

A packet is discarded as a whole if its first byte arrives while a previous packet is still unserviced. Bytes beyond the FIFO depth are discarded one at a time. The first byte of an accepted packet empties whatever is left in the FIFO.

Control/status layout, by bit position:

| Bit | Meaning |
|-----|---------|
| 0 | out-packet-ready |
| 1 | in-packet-ready |
| 2 | overrun |
| 3 | reads 0 |
| 4 | data-end |
| 5 | setup-end |
| 6 | serviced-out action bit, reads 0 |
| 7 | serviced-setup-end action bit, reads 0 |

Register addresses are: 0 control/status, 1 data, 2 count, 3 control. Bit 0 of the control register is the interrupt enable.

Top module: `ep0_csr`

## Requirements
- R1: After reset the control/status register reads 0x00, the count reads 0, `irq` is low and the control register reads 0x01 (interrupt enabled).
- R2: When the last byte of an accepted packet transfers, bit 0 of the control/status register reads 1 from the next cycle, and the count equals the number of bytes kept (1 to 16).
- R3: Each data-port read returns the next stored byte in arrival order and lowers the count by one; an 8-byte SETUP packet gives a count of 8; a data read with the FIFO empty returns 0x00 and leaves the count at 0.
- R4: Writing 1 to bit 6 of the control/status register clears out-packet-ready; with no other flag set the register then reads 0x00.
- R5: A single write of 0x50 clears out-packet-ready and sets data-end, giving a read value of 0x10.
- R6: A `status_done` pulse clears data-end and sets setup-end (bit 5) from the next cycle, which raises `irq` when enabled.
- R7: Setup-end is cleared only by writing 1 to bit 7; writes without bit 7 leave it set.
- R8: Writing 1 to bit 1 sets in-packet-ready (arming a zero-length reply); writing 0 there leaves it unchanged; an `in_sent` pulse clears it.
- R9: A packet whose first byte arrives while out-packet-ready is set is discarded entirely, and the stored bytes and count are unchanged. Bytes after the 16th of a packet are discarded. Either loss sets bit 2, which is cleared by writing 1 to bit 2.
- R10: `irq` equals the interrupt enable ANDed with (out-packet-ready OR setup-end).
- R11: Bits 3, 6 and 7 of the control/status register always read 0; writing 0 to an action bit has no effect.
- R12: `rx_ready` is 1 in every cycle, including during reset and while packets are being discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Receive byte ready, constant 1 |
| rx_data | input | 8 | Receive byte |
| rx_sop | input | 1 | Byte is first of packet |
| rx_eop | input | 1 | Byte is last of packet |
| status_done | input | 1 | Pulse: host finished status-stage OUT |
| in_sent | input | 1 | Pulse: armed IN packet was sent |
| cpu_addr | input | 2 | Register address |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (pops on data address) |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational from address |
| irq | output | 1 | Level interrupt |

## Verification
The hardest states to reach are the two discard paths, because both need a packet to arrive at a moment firmware would normally avoid.

The first is a packet whose first byte arrives while the previous packet is still flagged ready. The bench sends a packet and then sends a second one without writing the serviced-out bit in between. It then confirms the first packet's bytes are still intact.

The second is a packet longer than the FIFO. The bench sends 17 and 18 byte packets, which push past the depth, so the truncation and the overrun flag appear together.

Packet lengths 1 to 16 are swept in full, and every stored byte is read back against values computed from its length and position.

// File: rtl/ep0_pkg.sv
package ep0_pkg;
  localparam logic [1:0] ADDR_CSR   = 2'd0;
  localparam logic [1:0] ADDR_DATA  = 2'd1;
  localparam logic [1:0] ADDR_COUNT = 2'd2;
  localparam logic [1:0] ADDR_CTRL  = 2'd3;

  localparam int B_OPR = 0;
  localparam int B_IPR = 1;
  localparam int B_OVR = 2;
  localparam int B_DE  = 4;
  localparam int B_SE  = 5;
  localparam int B_SVO = 6;
  localparam int B_SVS = 7;
endpackage

// File: rtl/ep0_rx_fifo.sv
module ep0_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush,
  input  logic           push,
  input  logic [W-1:0]   din,
  input  logic           pop,
  output logic [W-1:0]   dout,
  output logic [$clog2(DEPTH):0] count,
  output logic           full,
  output logic           empty
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] DEPTH_C = DEPTH[AW:0];

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp, wp_base;

  assign wp_base = flush ? '0 : wp;
  assign count   = wp - rp;
  assign full    = (count == DEPTH_C);
  assign empty   = (count == '0);
  assign dout    = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push) mem[wp_base[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      wp <= wp_base + {{AW{1'b0}}, push};
      rp <= flush ? '0 : rp + {{AW{1'b0}}, pop};
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_C);
  assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !flush) |=> count == $past(count) - 1'b1);
endmodule

// File: rtl/ep0_flags.sv
module ep0_flags
  import ep0_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_opr,
  input  logic       set_ovr,
  input  logic       csr_we,
  input  logic       ctrl_we,
  input  logic [7:0] wdata,
  input  logic       status_done,
  input  logic       in_sent,
  output logic       opr,
  output logic       ipr,
  output logic       ovr,
  output logic       de,
  output logic       se,
  output logic       ien
);
  logic clr_opr, clr_se, clr_ovr, set_de, set_ipr;
  logic unused_wbits;

  assign clr_opr = csr_we & wdata[B_SVO];
  assign clr_se  = csr_we & wdata[B_SVS];
  assign clr_ovr = csr_we & wdata[B_OVR];
  assign set_de  = csr_we & wdata[B_DE];
  assign set_ipr = csr_we & wdata[B_IPR];
  assign unused_wbits = ^{wdata[3], wdata[5]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opr <= 1'b0;
      ipr <= 1'b0;
      ovr <= 1'b0;
      de  <= 1'b0;
      se  <= 1'b0;
      ien <= 1'b1;
    end else begin
      if (set_opr)      opr <= 1'b1;
      else if (clr_opr) opr <= 1'b0;
      if (set_ipr)      ipr <= 1'b1;
      else if (in_sent) ipr <= 1'b0;
      if (set_ovr)      ovr <= 1'b1;
      else if (clr_ovr) ovr <= 1'b0;
      if (status_done)  de <= 1'b0;
      else if (set_de)  de <= 1'b1;
      if (status_done)  se <= 1'b1;
      else if (clr_se)  se <= 1'b0;
      if (ctrl_we)      ien <= wdata[0];
    end
  end

  assert_opr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_opr && !set_opr) |=> !opr);
  assert_de_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_de && !status_done) |=> de);
  assert_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status_done |=> (se && !de));
  assert_se_only_action_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(se) |-> $past(csr_we && wdata[B_SVS]));
  assert_ipr_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ipr && !in_sent) |=> ipr);
endmodule

// File: rtl/ep0_csr.sv
module ep0_csr
  import ep0_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic [7:0] rx_data,
  input  logic       rx_sop,
  input  logic       rx_eop,
  input  logic       status_done,
  input  logic       in_sent,
  input  logic [1:0] cpu_addr,
  input  logic       cpu_wr,
  input  logic       cpu_rd,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  output logic       irq
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic          opr, ipr, ovr, de, se, ien;
  logic          dropping, drop_now, start;
  logic          flush, push, pop, set_opr, set_ovr;
  logic [7:0]    dout;
  logic [CW-1:0] count;
  logic          full, empty;

  assign rx_ready = 1'b1;
  assign start    = rx_valid & rx_sop;
  assign drop_now = start ? opr : dropping;
  assign flush    = start & ~opr;
  assign push     = rx_valid & ~drop_now & (rx_sop | ~full);
  assign set_ovr  = rx_valid & (drop_now | (~rx_sop & full));
  assign set_opr  = rx_valid & rx_eop & ~drop_now;
  assign pop      = cpu_rd & (cpu_addr == ADDR_DATA) & ~empty;

  always_ff @(posedge clk) begin
    if (!rst_n)     dropping <= 1'b0;
    else if (start) dropping <= opr;
  end

  ep0_rx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .din(rx_data),
    .pop(pop), .dout(dout), .count(count), .full(full), .empty(empty)
  );

  ep0_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_opr(set_opr), .set_ovr(set_ovr),
    .csr_we(cpu_wr & (cpu_addr == ADDR_CSR)),
    .ctrl_we(cpu_wr & (cpu_addr == ADDR_CTRL)),
    .wdata(cpu_wdata), .status_done(status_done), .in_sent(in_sent),
    .opr(opr), .ipr(ipr), .ovr(ovr), .de(de), .se(se), .ien(ien)
  );

  always_comb begin
    case (cpu_addr)
      ADDR_CSR:   cpu_rdata = {2'b00, se, de, 1'b0, ovr, ipr, opr};
      ADDR_DATA:  cpu_rdata = empty ? 8'h00 : dout;
      ADDR_COUNT: cpu_rdata = {{(8-CW){1'b0}}, count};
      default:    cpu_rdata = {7'b0, ien};
    endcase
  end

  assign irq = ien & (opr | se);

  assert_opr_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_opr |=> opr);
  assert_drop_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && opr && !pop) |=> $stable(count));
  assert_ready_R12: assert property (@(posedge clk) rx_ready);
endmodule

// File: tb/sim_ep0_csr.sv
module sim_ep0_csr;
  import ep0_pkg::*;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 0, rx_sop = 0, rx_eop = 0, status_done = 0, in_sent = 0;
  logic [7:0] rx_data = 0;
  logic [1:0] cpu_addr = 0;
  logic cpu_wr = 0, cpu_rd = 0;
  logic [7:0] cpu_wdata = 0;
  logic [7:0] cpu_rdata;
  logic rx_ready, irq;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  ep0_csr u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int len, input int i);
    return 8'((len * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic send(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = pat(len, i);
      rx_sop = (i == 0); rx_eop = (i == len - 1);
    end
    @(negedge clk);
    rx_valid = 0; rx_sop = 0; rx_eop = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
    @(negedge clk);
    cpu_wr = 0;
  endtask

  task automatic peek(input logic [1:0] a, output int v);
    cpu_addr = a; #1; v = cpu_rdata;
  endtask

  task automatic pop_byte(output int v);
    @(negedge clk);
    cpu_addr = ADDR_DATA; cpu_rd = 1; #1; v = cpu_rdata;
    @(negedge clk);
    cpu_rd = 0;
  endtask

  task automatic pulse(input bit which);
    @(negedge clk);
    if (which) status_done = 1; else in_sent = 1;
    @(negedge clk);
    status_done = 0; in_sent = 0;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    chk("R12 ready in reset", int'(rx_ready), 1);
    rst_n = 1;
    @(negedge clk);
    peek(ADDR_CSR, v);   chk("R1 csr", v, 0);
    peek(ADDR_COUNT, v); chk("R1 count", v, 0);
    peek(ADDR_CTRL, v);  chk("R1 ctrl", v, 1);
    chk("R1 irq", int'(irq), 0);

    for (int len = 1; len <= 16; len++) begin
      send(len);
      peek(ADDR_CSR, v);   chk("R2 opr", v, 1);
      peek(ADDR_COUNT, v); chk("R2 count", v, len);
      chk("R10 irq on opr", int'(irq), 1);
      for (int i = 0; i < len; i++) begin
        pop_byte(v); chk("R3 data", v, int'(pat(len, i)));
        peek(ADDR_COUNT, v); chk("R3 count dec", v, len - i - 1);
      end
      pop_byte(v); chk("R3 empty read", v, 0);
      peek(ADDR_COUNT, v); chk("R3 empty count", v, 0);
      wr(ADDR_CSR, 8'h00);
      peek(ADDR_CSR, v); chk("R11 zero write keeps opr", v, 1);
      wr(ADDR_CSR, 8'h40);
      peek(ADDR_CSR, v); chk("R4 cleared", v, 0);
      chk("R10 irq low", int'(irq), 0);
    end

    // SETUP then a packet while unserviced
    send(8);
    peek(ADDR_COUNT, v); chk("R3 setup count 8", v, 8);
    send(4);
    peek(ADDR_COUNT, v); chk("R9 drop count", v, 8);
    peek(ADDR_CSR, v);   chk("R9 drop csr", v, 8'h05);
    pop_byte(v); chk("R9 kept byte", v, int'(pat(8, 0)));
    wr(ADDR_CSR, 8'h44);
    peek(ADDR_CSR, v); chk("R9 ovr clear", v, 0);

    // oversize packets
    for (int len = 17; len <= 18; len++) begin
      send(len);
      peek(ADDR_COUNT, v); chk("R9 trunc count", v, 16);
      peek(ADDR_CSR, v);   chk("R9 trunc csr", v, 8'h05);
      for (int i = 0; i < 16; i++) begin
        pop_byte(v); chk("R9 trunc data", v, int'(pat(len, i)));
      end
      wr(ADDR_CSR, 8'h44);
    end

    // control write flow
    send(2);
    wr(ADDR_CSR, 8'h50);
    peek(ADDR_CSR, v); chk("R5 combined", v, 8'h10);
    chk("R10 irq after R5", int'(irq), 0);
    pulse(1);
    peek(ADDR_CSR, v); chk("R6 status", v, 8'h20);
    chk("R6 irq", int'(irq), 1);
    wr(ADDR_CSR, 8'h7F);
    peek(ADDR_CSR, v); chk("R7 se kept", v, 8'h32);
    pulse(0);
    pulse(1);
    peek(ADDR_CSR, v); chk("R7 se kept 2", v, 8'h20);
    wr(ADDR_CSR, 8'h80);
    peek(ADDR_CSR, v); chk("R7 se cleared", v, 0);
    chk("R10 irq after R7", int'(irq), 0);

    // in-packet-ready
    wr(ADDR_CSR, 8'h02);
    peek(ADDR_CSR, v); chk("R8 ipr set", v, 8'h02);
    wr(ADDR_CSR, 8'h00);
    peek(ADDR_CSR, v); chk("R8 ipr kept", v, 8'h02);
    pulse(0);
    peek(ADDR_CSR, v); chk("R8 ipr cleared", v, 0);

    // mask
    wr(ADDR_CTRL, 8'h00);
    send(3);
    chk("R10 masked irq", int'(irq), 0);
    peek(ADDR_CSR, v); chk("R10 masked csr", v, 1);
    wr(ADDR_CTRL, 8'h01);
    chk("R10 unmasked irq", int'(irq), 1);
    wr(ADDR_CSR, 8'h40);

    // read-as-zero bits
    wr(ADDR_CSR, 8'hDA);
    peek(ADDR_CSR, v); chk("R11 rsvd bits zero", v, 8'h12);
    chk("R12 ready", int'(rx_ready), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule